// File: doc/BRIEF.md
# Biphasic Stimulation Pulse Sequencer

This block produces the digital timing and switch controls for a multi-channel current stimulator. One accepted trigger plays one pulse. A pulse has four intervals in a fixed order. First comes a current phase whose polarity is selectable. Next is a quiet gap. Then a current phase of the opposite polarity. Last is a passive drain interval, in which the electrodes are shorted to remove residual charge. Each interval has its own width in microseconds. A prescaler turns the system clock into a 1 µs time base.

The trigger comes from the command decoder of the serial control path. Each channel's source, sink and drain enables are the phase flags AND-ed with per-channel enable bits. The 8-bit global current code and the 3-bit per-channel amplitude codes pass through to the analog stage unchanged. All configuration is captured when a pulse starts, so the host may rewrite it at any time.

Top module: `stim_pulse_seq`

## Requirements
- R1: Intervals run in the order first current phase, gap, second current phase, drain. With `first_neg_i`=0 the first phase drives source (anodic) and the second drives sink. With `first_neg_i`=1 the two polarities swap.
- R2: Each interval lasts exactly width × CLK_PER_US clock cycles, for any width from 1 to 1023.
- R3: An interval whose width is zero is skipped and never entered. Setting the second-phase width to zero gives a monophasic pulse.
- R4: Source and sink are never high together on any channel. Drain is high only during the drain interval. During the gap and while idle, all three enables are low.
- R5: Outputs follow the accepting clock edge by one cycle. `busy_o` stays high from then until the drain interval ends. A trigger that arrives while a pulse is running has no effect on that pulse.
- R6: Configuration written while a pulse runs does not change that pulse or the code outputs. It takes effect at the next accepted trigger.
- R7: On channel i, `src_o[i]` needs `ch_en_i[i]` and `pos_en_i[i]`, `snk_o[i]` needs `ch_en_i[i]` and `neg_en_i[i]`, and `drain_o[i]` needs `ch_en_i[i]`. All of these are the values captured at the trigger.
- R8: `gcode_o` and `lcode_o` show the codes captured at the last accepted trigger. Channel i's amplitude code sits in bits [3i+2:3i]. Both outputs are zero after reset.
- R9: While reset is high, and after it is released until a trigger is accepted, every enable, `busy_o` and both code outputs are zero.
- R10: A trigger that arrives with all four widths at zero produces no activity. `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | One-cycle pulse request from the command decoder |
| first_neg_i | input | 1 | 1: first current phase is sink (cathodic) |
| w_first_i | input | W_US | First current phase width in µs |
| w_gap_i | input | W_US | Gap width in µs |
| w_second_i | input | W_US | Second current phase width in µs |
| w_drain_i | input | W_US | Drain interval width in µs |
| ch_en_i | input | NCH | Per-channel enable |
| pos_en_i | input | NCH | Per-channel source enable |
| neg_en_i | input | NCH | Per-channel sink enable |
| gcode_i | input | GW | Global current code |
| lcode_i | input | NCH*LW | Per-channel amplitude codes |
| src_o | output | NCH | Source switch enables |
| snk_o | output | NCH | Sink switch enables |
| drain_o | output | NCH | Discharge switch enables |
| busy_o | output | 1 | Pulse in progress |
| gcode_o | output | GW | Captured global code |
| lcode_o | output | NCH*LW | Captured amplitude codes |

## Verification
Call the clock edge that accepts a trigger edge k. The captured codes are visible just after edge k. The enables and `busy_o` change one edge later, at k+1, and each interval then holds for width × CLK_PER_US edges. The bench samples on the falling edge. For each table entry it builds the expected {busy, drain, sink, source} value for every cycle from the widths. It compares from the sample after edge k until two cycles past the end of the pulse. The directed tests count cycles in the same way to land inside a chosen interval, or on its first and last cycle.

// File: rtl/stim_pkg.sv
package stim_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_FIRST  = 3'd1,
    PH_GAP    = 3'd2,
    PH_SECOND = 3'd3,
    PH_DRAIN  = 3'd4
  } phase_e;
  localparam int unsigned N_INTERVALS = 4;
endpackage

// File: rtl/stim_tick_gen.sv
module stim_tick_gen #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run)       cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // R2: the prescaler never leaves its range, so every microsecond is DIV cycles
  assert_prescale_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R2: a restart always gives a full microsecond before the next tick
  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0));
endmodule

// File: rtl/stim_phase_fsm.sv
module stim_phase_fsm
  import stim_pkg::*;
#(
  parameter int unsigned W_US = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 trig,
  input  logic                 first_neg,
  input  logic [3:0][W_US-1:0] widths,
  input  logic                 tick,
  output logic                 start,
  output logic                 load,
  output logic                 active,
  output logic                 src_f,
  output logic                 snk_f,
  output logic                 drain_f,
  output logic                 busy_f
);
  phase_e               phase, ph_n;
  logic [3:0][W_US-1:0] w_q, wsel;
  logic                 pol_q, pol_n;
  logic [W_US-1:0]      rem, rem_n;
  logic [3:0]           nz;
  logic                 adv;
  int                   from_idx;
  logic                 found;

  assign active = (phase != PH_IDLE);
  assign start  = trig && !active;
  assign adv    = active && tick && (rem == W_US'(1));
  assign load   = start || adv;
  assign wsel   = start ? widths : w_q;
  assign pol_n  = start ? first_neg : pol_q;

  always_comb begin
    for (int i = 0; i < 4; i++) nz[i] = |wsel[i];
    from_idx = start ? 0 : int'(phase);
    found    = 1'b0;
    ph_n     = phase;
    if (load) begin
      ph_n = PH_IDLE;
      for (int i = 0; i < 4; i++) begin
        if (!found && (i >= from_idx) && nz[i]) begin
          found = 1'b1;
          ph_n  = phase_e'(3'(i + 1));
        end
      end
    end
    rem_n = rem;
    if (load) begin
      rem_n = '0;
      for (int i = 0; i < 4; i++)
        if (int'(ph_n) == i + 1) rem_n = wsel[i];
    end else if (active && tick) begin
      rem_n = rem - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      rem     <= '0;
      w_q     <= '0;
      pol_q   <= 1'b0;
      src_f   <= 1'b0;
      snk_f   <= 1'b0;
      drain_f <= 1'b0;
      busy_f  <= 1'b0;
    end else begin
      phase   <= ph_n;
      rem     <= rem_n;
      pol_q   <= pol_n;
      if (start) w_q <= widths;
      src_f   <= ((ph_n == PH_FIRST) && !pol_n) || ((ph_n == PH_SECOND) && pol_n);
      snk_f   <= ((ph_n == PH_FIRST) && pol_n)  || ((ph_n == PH_SECOND) && !pol_n);
      drain_f <= (ph_n == PH_DRAIN);
      busy_f  <= (ph_n != PH_IDLE);
    end
  end

  // R2: an active interval always has microseconds left to count
  assert_rem_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    active |-> (rem != '0));
  // R3: an interval programmed to zero width is never entered
  assert_skip_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (w_q[int'(phase) - 1] != '0));
  // R5: a trigger during a pulse leaves the captured widths and polarity alone
  assert_retrig_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (active && trig) |=> ($stable(w_q) && $stable(pol_q)));
  // R1: the drain interval is followed by idle, never by a current phase
  assert_drain_last_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DRAIN && adv) |=> (phase == PH_IDLE));
endmodule

// File: rtl/stim_chan_gate.sv
module stim_chan_gate #(
  parameter int unsigned NCH = 64,
  parameter int unsigned GW  = 8,
  parameter int unsigned LW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              src_f,
  input  logic              snk_f,
  input  logic              drain_f,
  input  logic              busy_f,
  input  logic [NCH-1:0]    ch_en,
  input  logic [NCH-1:0]    pos_en,
  input  logic [NCH-1:0]    neg_en,
  input  logic [GW-1:0]     gcode,
  input  logic [NCH*LW-1:0] lcode,
  output logic [NCH-1:0]    src_o,
  output logic [NCH-1:0]    snk_o,
  output logic [NCH-1:0]    drain_o,
  output logic              busy_o,
  output logic [GW-1:0]     gcode_o,
  output logic [NCH*LW-1:0] lcode_o
);
  logic [NCH-1:0] ch_q, pos_q, neg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q    <= '0;
      pos_q   <= '0;
      neg_q   <= '0;
      gcode_o <= '0;
      lcode_o <= '0;
      busy_o  <= 1'b0;
    end else begin
      busy_o <= busy_f;
      if (start) begin
        ch_q    <= ch_en;
        pos_q   <= pos_en;
        neg_q   <= neg_en;
        gcode_o <= gcode;
        lcode_o <= lcode;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        src_o[i]   <= 1'b0;
        snk_o[i]   <= 1'b0;
        drain_o[i] <= 1'b0;
      end else begin
        src_o[i]   <= src_f   & ch_q[i] & pos_q[i];
        snk_o[i]   <= snk_f   & ch_q[i] & neg_q[i];
        drain_o[i] <= drain_f & ch_q[i];
      end
    end
  end

  // R4: no channel ever sources and sinks together
  assert_src_snk_excl_R4: assert property (@(posedge clk) disable iff (rst)
    (src_o & snk_o) == '0);
  // R4: the drain switch never overlaps a current phase
  assert_drain_alone_R4: assert property (@(posedge clk) disable iff (rst)
    (|drain_o) |-> (!(|src_o) && !(|snk_o)));
  // R4: nothing is driven while the block is idle
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!(|src_o) && !(|snk_o) && !(|drain_o)));
  // R7: drive only on channels enabled at the trigger
  assert_gate_mask_R7: assert property (@(posedge clk) disable iff (rst)
    ((src_o & ~(ch_q & pos_q)) == '0) && ((snk_o & ~(ch_q & neg_q)) == '0));
  // R6: the codes hold for the whole pulse
  assert_codes_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_f && !start) |=> ($stable(gcode_o) && $stable(lcode_o)));
endmodule

// File: rtl/stim_pulse_seq.sv
module stim_pulse_seq #(
  parameter int unsigned NCH        = 64,
  parameter int unsigned W_US       = 10,
  parameter int unsigned GW         = 8,
  parameter int unsigned LW         = 3,
  parameter int unsigned CLK_PER_US = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              first_neg_i,
  input  logic [W_US-1:0]   w_first_i,
  input  logic [W_US-1:0]   w_gap_i,
  input  logic [W_US-1:0]   w_second_i,
  input  logic [W_US-1:0]   w_drain_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic [NCH-1:0]    pos_en_i,
  input  logic [NCH-1:0]    neg_en_i,
  input  logic [GW-1:0]     gcode_i,
  input  logic [NCH*LW-1:0] lcode_i,
  output logic [NCH-1:0]    src_o,
  output logic [NCH-1:0]    snk_o,
  output logic [NCH-1:0]    drain_o,
  output logic              busy_o,
  output logic [GW-1:0]     gcode_o,
  output logic [NCH*LW-1:0] lcode_o
);
  logic [3:0][W_US-1:0] widths;
  logic start, load, active, tick;
  logic src_f, snk_f, drain_f, busy_f;

  assign widths = {w_drain_i, w_second_i, w_gap_i, w_first_i};

  stim_tick_gen #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst(rst), .restart(load), .run(active), .tick(tick)
  );

  stim_phase_fsm #(.W_US(W_US)) u_fsm (
    .clk(clk), .rst(rst), .trig(trig_i), .first_neg(first_neg_i),
    .widths(widths), .tick(tick), .start(start), .load(load),
    .active(active), .src_f(src_f), .snk_f(snk_f), .drain_f(drain_f),
    .busy_f(busy_f)
  );

  stim_chan_gate #(.NCH(NCH), .GW(GW), .LW(LW)) u_gate (
    .clk(clk), .rst(rst), .start(start), .src_f(src_f), .snk_f(snk_f),
    .drain_f(drain_f), .busy_f(busy_f), .ch_en(ch_en_i), .pos_en(pos_en_i),
    .neg_en(neg_en_i), .gcode(gcode_i), .lcode(lcode_i), .src_o(src_o),
    .snk_o(snk_o), .drain_o(drain_o), .busy_o(busy_o), .gcode_o(gcode_o),
    .lcode_o(lcode_o)
  );

  // R5: busy only rises one cycle after a trigger
  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start, 2));
endmodule

// File: tb/sim_stim_pulse_seq.sv
module sim_stim_pulse_seq;
  localparam int NCH = 8;
  localparam int W   = 10;
  localparam int P   = 3;
  localparam int NV  = 8;

  // {first_neg, first, gap, second, drain}
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 10'd2,    10'd1, 10'd2, 10'd3},   // R1 symmetric, anodic first
    {1'b1, 10'd2,    10'd1, 10'd2, 10'd3},   // R1 cathodic first
    {1'b0, 10'd3,    10'd2, 10'd1, 10'd4},   // R2 asymmetric
    {1'b0, 10'd2,    10'd1, 10'd0, 10'd2},   // R3 monophasic
    {1'b1, 10'd1,    10'd0, 10'd1, 10'd1},   // R3 no gap
    {1'b0, 10'd0,    10'd0, 10'd0, 10'd2},   // R3 drain only
    {1'b1, 10'd1,    10'd1, 10'd1, 10'd0},   // R3 no drain
    {1'b0, 10'd1023, 10'd0, 10'd0, 10'd1}    // R2 maximum width
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0, first_neg = 1'b0;
  logic [W-1:0] w1 = '0, w2 = '0, w3 = '0, w4 = '0;
  logic [NCH-1:0] ch_en = '0, pos_en = '0, neg_en = '0;
  logic [7:0] gcode = '0;
  logic [NCH*3-1:0] lcode = '0;
  logic [NCH-1:0] src, snk, drn;
  logic busy;
  logic [7:0] gcode_q;
  logic [NCH*3-1:0] lcode_q;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stim_pulse_seq #(.NCH(NCH), .W_US(W), .GW(8), .LW(3), .CLK_PER_US(P)) u0 (
    .clk(clk), .rst(rst), .trig_i(trig), .first_neg_i(first_neg),
    .w_first_i(w1), .w_gap_i(w2), .w_second_i(w3), .w_drain_i(w4),
    .ch_en_i(ch_en), .pos_en_i(pos_en), .neg_en_i(neg_en),
    .gcode_i(gcode), .lcode_i(lcode), .src_o(src), .snk_o(snk),
    .drain_o(drn), .busy_o(busy), .gcode_o(gcode_q), .lcode_o(lcode_q)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // returns at the falling edge after the accepting edge (sample j=0)
  task automatic fire();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  // {busy, drain, sink, source} for sample j after the accepting edge
  function automatic logic [3:0] exp_code(input int j, input bit pol,
      input int a1, input int a2, input int a3, input int a4);
    int idx, b1, b2, b3, b4;
    if (j == 0) return 4'b0000;
    idx = j - 1;
    b1 = a1 * P; b2 = b1 + a2 * P; b3 = b2 + a3 * P; b4 = b3 + a4 * P;
    if (idx < b1) return pol ? 4'b1010 : 4'b1001;
    if (idx < b2) return 4'b1000;
    if (idx < b3) return pol ? 4'b1001 : 4'b1010;
    if (idx < b4) return 4'b1100;
    return 4'b0000;
  endfunction

  task automatic run_vec(input bit pol, input int a1, input int a2,
                         input int a3, input int a4, input string req);
    int len;
    logic [3:0] got, want, bad_got, bad_want;
    bit ok;
    ok = 1'b1; bad_got = '0; bad_want = '0;
    first_neg = pol;
    w1 = W'(a1); w2 = W'(a2); w3 = W'(a3); w4 = W'(a4);
    ch_en = '1; pos_en = '1; neg_en = '1;
    len = (a1 + a2 + a3 + a4) * P;
    fire();
    for (int j = 0; j <= len + 2; j++) begin
      got  = {busy, drn[0], snk[0], src[0]};
      want = exp_code(j, pol, a1, a2, a3, a4);
      if (ok && got !== want) begin
        ok = 1'b0; bad_got = got; bad_want = want;
        $display("  mismatch at sample %0d", j);
      end
      @(negedge clk);
    end
    chk(ok, req, 64'(bad_got), 64'(bad_want));
  endtask

  initial begin
    // R9: reset state
    wait_n(3);
    chk({src, snk, drn, busy} == '0, "R9 outputs in reset", 64'({src, snk, drn, busy}), 0);
    @(negedge clk) rst = 1'b0;
    wait_n(2);
    chk({src, snk, drn, busy} == '0, "R9 outputs after reset", 64'({src, snk, drn, busy}), 0);
    chk({gcode_q, lcode_q} == '0, "R8 codes zero after reset", 64'({gcode_q, lcode_q}), 0);

    // table walk: R1 R2 R3 R4 R5
    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][40], int'(VEC[v][39:30]), int'(VEC[v][29:20]),
              int'(VEC[v][19:10]), int'(VEC[v][9:0]), $sformatf("R1/R2/R3/R4 vector %0d", v));

    // R7: per-channel gating
    ch_en = 8'b1011_0110; pos_en = 8'b1100_1100; neg_en = 8'b0101_1010;
    first_neg = 1'b0; w1 = 10'd2; w2 = 10'd1; w3 = 10'd2; w4 = 10'd2;
    fire();
    wait_n(1);
    chk(src == (ch_en & pos_en) && snk == '0, "R7 source gating", 64'(src), 64'(ch_en & pos_en));
    wait_n(9);   // j=10, first cycle of second phase
    chk(snk == (ch_en & neg_en) && src == '0, "R7 sink gating", 64'(snk), 64'(ch_en & neg_en));
    wait_n(6);   // j=16, first cycle of drain
    chk(drn == ch_en, "R7 drain gating", 64'(drn), 64'(ch_en));
    wait_n(8);

    // R5/R6: retrigger with new configuration during a pulse
    ch_en = '1; pos_en = '1; neg_en = '1;
    first_neg = 1'b0; w1 = 10'd4; w2 = 10'd0; w3 = 10'd0; w4 = 10'd2;
    gcode = 8'h3C; lcode = 24'h0FACE1;
    fire();
    chk(gcode_q == 8'h3C && lcode_q == 24'h0FACE1, "R8 codes captured at trigger",
        64'({gcode_q, lcode_q}), 64'({8'h3C, 24'h0FACE1}));
    wait_n(3);   // j=3
    first_neg = 1'b1; w1 = 10'd1; w2 = 10'd1; w3 = 10'd1; w4 = 10'd1;
    gcode = 8'hA5; lcode = 24'h123456;
    trig = 1'b1;
    wait_n(1);   // j=4
    trig = 1'b0;
    chk(gcode_q == 8'h3C, "R6 code held during pulse", 64'(gcode_q), 64'(8'h3C));
    chk({busy, snk[0], src[0]} == 3'b101, "R5 retrigger ignored, source continues",
        64'({busy, snk[0], src[0]}), 64'(3'b101));
    wait_n(8);   // j=12, last source cycle
    chk(src[0] == 1'b1 && drn[0] == 1'b0, "R2 source holds 12 cycles", 64'({drn[0], src[0]}), 64'(2'b01));
    wait_n(1);   // j=13, drain begins
    chk({busy, drn[0]} == 2'b11, "R5 drain after source", 64'({busy, drn[0]}), 64'(2'b11));
    wait_n(5);   // j=18, last drain cycle
    chk({busy, drn[0]} == 2'b11, "R5 busy through drain", 64'({busy, drn[0]}), 64'(2'b11));
    wait_n(1);   // j=19
    chk({busy, drn[0]} == 2'b00, "R5 busy falls after drain", 64'({busy, drn[0]}), 64'(2'b00));
    wait_n(1);
    run_vec(1'b1, 1, 1, 1, 1, "R6 new configuration at next trigger");
    chk(gcode_q == 8'hA5 && lcode_q == 24'h123456, "R6 R8 new codes after next trigger",
        64'({gcode_q, lcode_q}), 64'({8'hA5, 24'h123456}));

    // R10: all widths zero
    w1 = '0; w2 = '0; w3 = '0; w4 = '0;
    fire();
    begin
      bit quiet;
      quiet = 1'b1;
      for (int j = 0; j < 6; j++) begin
        if (busy || (|src) || (|snk) || (|drn)) quiet = 1'b0;
        @(negedge clk);
      end
      chk(quiet, "R10 zero widths give no activity", 64'(busy), 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule